// File: doc/BRIEF.md
# Keyed Flash Row-Erase Controller

This block guards and sequences row erases of an on-chip program memory. A CPU reaches it through a small byte-wide register port. That port holds a 16-bit target address split over two bytes, a control byte and a key register. An erase can only start after a two-byte unlock key has been written to the key register, in order and with no other register write in between. The key must then be followed directly by a control write that sets the start bit. Any address inside a row selects the whole row, and the flash side receives the row-aligned address.

After an accepted start write, the controller gives the CPU two setup cycles. The two instructions in that window are treated as no-ops. The controller then holds instruction execution through a stall output for the whole erase time. The peripheral-enable output stays high during the stall, so the stall is not a sleep state. The erase time is a cycle count parameter, nominally 2 ms worth of clock cycles, and the flash array can stretch it with a busy input. When the stall releases, execution resumes at the third instruction after the start write.

Top module: `flash_row_erase_ctl`

Register map (reg_addr):
- 0 holds the address low byte.
- 1 holds the address high byte.
- 2 is the control byte: bit0 start, bit1 write-enable, bit2 erase-select, bit3 config-space select.
- 3 is the key register, which reads as 0.

## Requirements
- R1: fl_row_addr equals the 16-bit address register with its low log2(ROW_WORDS) bits forced to 0, captured at the accepted start write.
- R2: A control write (reg_addr 2) starts an erase only if its data has bit0=1, bit1=1, bit2=1 and bit3=0. Otherwise no setup or stall follows, and control bit0 reads back as 0.
- R3: The unlock is 0x55 written to reg_addr 3, immediately followed by 0xAA written to reg_addr 3.
- R4: Any of the following leaves the unlock cleared: a key write of any other value, a write to reg_addr 0 or 1, or any control write.
- R5: cpu_nop is high for exactly the two cycles after the accepted start write. cpu_stall rises in the cycle after that.
- R6: With fl_busy low, cpu_stall stays high for exactly ERASE_CYCLES cycles. While fl_busy is high, the stall does not end.
- R7: periph_en is high whenever cpu_stall is high, and from the first clock after reset.
- R8: Control bit0 reads 1 from the accepted start write until the erase completes, then reads 0.
- R9: Register writes made during setup or erase have no effect.
- R10: fl_erase_req is a one-cycle pulse in the first stall cycle. fl_row_addr stays stable while the stall lasts.
- R11: After reset, cpu_stall, cpu_nop and fl_erase_req are 0, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| fl_erase_req | output | 1 | Row-erase request pulse to the flash |
| fl_row_addr | output | 16 | Row-aligned erase address |
| fl_busy | input | 1 | Flash still busy; holds the erase open |
| cpu_nop | output | 1 | Setup window, CPU executes no-ops |
| cpu_stall | output | 1 | Holds CPU instruction execution |
| periph_en | output | 1 | Clock and peripheral enable, stays on in a stall |

## Verification
The bench builds the controller with ROW_WORDS=16 and ERASE_CYCLES=20. A full erase then fits in a few dozen cycles, so forty random key-and-start sequences can be run to completion, with an exact stall length counted on every one. The 16-word row masks four address bits. That choice checks that the mask follows the parameter rather than a fixed width. The small erase count also lets a held fl_busy keep the stall open well past ERASE_CYCLES within a short run.

// File: rtl/flash_row_erase_ctl.sv
module flash_row_erase_ctl #(
  parameter int ROW_WORDS    = 32,
  parameter int ERASE_CYCLES = 32000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        fl_erase_req,
  output logic [15:0] fl_row_addr,
  input  logic        fl_busy,
  output logic        cpu_nop,
  output logic        cpu_stall,
  output logic        periph_en
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [15:0] ROW_MASK = ~16'(ROW_WORDS - 1);

  typedef enum logic [1:0] {IDLE, SETUP, ERASE} state_t;

  state_t st;
  logic [CNT_W-1:0] cnt;
  logic [15:0] addr, row;
  logic wren, esel, cfg;
  logic [1:0] ulk;

  wire idle  = (st == IDLE);
  wire wr_ok = reg_wr && idle;
  wire go    = wr_ok && reg_addr == 2'd2 && ulk == 2'd2 &&
               reg_wdata[0] && reg_wdata[1] && reg_wdata[2] && !reg_wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      row <= '0;
      {cfg, esel, wren} <= '0;
      ulk <= '0;
      periph_en <= 1'b0;
    end else begin
      periph_en <= 1'b1;
      if (wr_ok) begin
        ulk <= 2'd0;
        case (reg_addr)
          2'd0: addr[7:0]  <= reg_wdata;
          2'd1: addr[15:8] <= reg_wdata;
          2'd2: {cfg, esel, wren} <= reg_wdata[3:1];
          default: begin
            if (reg_wdata == 8'h55) ulk <= 2'd1;
            else if (reg_wdata == 8'hAA && ulk == 2'd1) ulk <= 2'd2;
          end
        endcase
      end
      if (go) row <= addr & ROW_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
    end else begin
      case (st)
        IDLE: if (go) begin
          st <= SETUP;
          cnt <= '0;
        end
        SETUP: begin
          if (cnt == CNT_W'(1)) begin
            st <= ERASE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ERASE: begin
          if (cnt == LAST) begin
            if (!fl_busy) st <= IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign cpu_nop      = (st == SETUP);
  assign cpu_stall    = (st == ERASE);
  assign fl_erase_req = cpu_stall && cnt == '0;
  assign fl_row_addr  = row;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = addr[7:0];
      2'd1:    reg_rdata = addr[15:8];
      2'd2:    reg_rdata = {4'b0, cfg, esel, wren, !idle};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_row_erase_ctl_checker.sv
module flash_row_erase_ctl_checker #(
  parameter int ROW_WORDS    = 32,
  parameter int ERASE_CYCLES = 32000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        fl_erase_req,
  input logic [15:0] fl_row_addr,
  input logic        fl_busy,
  input logic        cpu_nop,
  input logic        cpu_stall,
  input logic        periph_en
);
  localparam logic [15:0] OFS = 16'(ROW_WORDS - 1);
  int unsigned stall_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_len <= 0;
    else if (cpu_stall) stall_len <= stall_len + 1;
    else stall_len <= 0;
  end

  a_r1_row_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_row_addr & OFS) == 16'h0);
  a_r5_nop_before_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> $past(cpu_nop));
  a_r5_nop_then_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_nop) |-> cpu_stall);
  a_r6_min_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> stall_len >= ERASE_CYCLES);
  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall && fl_busy |=> cpu_stall);
  a_r7_periph_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> periph_en);
  a_r10_req_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase_req |-> cpu_stall && !$past(cpu_stall));
  a_r10_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall && $past(cpu_stall) |-> $stable(fl_row_addr));
endmodule

bind flash_row_erase_ctl flash_row_erase_ctl_checker #(
  .ROW_WORDS(ROW_WORDS), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_erase_req(fl_erase_req),
  .fl_row_addr(fl_row_addr), .fl_busy(fl_busy), .cpu_nop(cpu_nop),
  .cpu_stall(cpu_stall), .periph_en(periph_en)
);

// File: tb/flash_row_erase_ctl_bench.sv
module flash_row_erase_ctl_bench;
  localparam int RW = 16;
  localparam int EC = 20;

  logic clk = 0, rst_n = 0, reg_wr = 0, fl_busy = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic fl_erase_req, cpu_nop, cpu_stall, periph_en;
  logic [15:0] fl_row_addr;

  int checks = 0, failures = 0;
  logic [1:0] m_ulk = 0;
  logic [15:0] m_addr = 0;

  flash_row_erase_ctl #(.ROW_WORDS(RW), .ERASE_CYCLES(EC)) u_flash_row_erase_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_erase_req(fl_erase_req),
    .fl_row_addr(fl_row_addr), .fl_busy(fl_busy), .cpu_nop(cpu_nop),
    .cpu_stall(cpu_stall), .periph_en(periph_en)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] row_of(input logic [15:0] a);
    return a & ~16'(RW - 1);
  endfunction

  function automatic bit starts(input logic [1:0] u, input logic [7:0] d);
    return u == 2'd2 && d[0] && d[1] && d[2] && !d[3];
  endfunction

  // write while idle; model tracks unlock and address
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (a == 2'd3) m_ulk = (d == 8'h55) ? 2'd1 : (d == 8'hAA && m_ulk == 2'd1) ? 2'd2 : 2'd0;
    else m_ulk = 0;
    if (a == 2'd0) m_addr[7:0] = d;
    if (a == 2'd1) m_addr[15:8] = d;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // called at the negedge right after a start write was accepted
  task automatic run_erase(input logic [15:0] exp_row);
    int n, reqs;
    logic [7:0] c;
    rd(2'd2, c);
    chk(c[0] == 1'b1, "R8 start reads 1 in setup", c[0], 1);
    chk(cpu_nop && !cpu_stall, "R5 setup cycle 1", {cpu_nop, cpu_stall}, 2'b10);
    @(negedge clk);
    chk(cpu_nop && !cpu_stall, "R5 setup cycle 2", {cpu_nop, cpu_stall}, 2'b10);
    @(negedge clk);
    chk(cpu_stall && !cpu_nop, "R5 stall starts", {cpu_nop, cpu_stall}, 2'b01);
    chk(fl_row_addr == exp_row, "R1 row address", fl_row_addr, exp_row);
    n = 0; reqs = 0;
    while (cpu_stall) begin
      n++;
      if (fl_erase_req) reqs++;
      if (!periph_en) chk(0, "R7 periph_en in stall", 0, 1);
      @(negedge clk);
    end
    chk(reqs == 1, "R10 one request pulse", reqs, 1);
    chk(n == EC, "R6 stall length", n, EC);
    rd(2'd2, c);
    chk(c[0] == 1'b0, "R8 start clears at end", c[0], 0);
  endtask

  task automatic try_start(input logic [7:0] d);
    bit exp;
    logic [7:0] c;
    exp = starts(m_ulk, d);
    wr(2'd2, d);
    chk(cpu_nop == exp, "R2 start acceptance", cpu_nop, exp);
    if (exp) run_erase(row_of(m_addr));
    else begin
      rd(2'd2, c);
      chk(c == {4'b0, d[3:1], 1'b0}, "R2 rejected start reads 0", c, {4'b0, d[3:1], 1'b0});
      @(negedge clk); @(negedge clk);
      chk(!cpu_stall, "R2 no stall", cpu_stall, 0);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cpu_stall && !cpu_nop && !fl_erase_req, "R11 reset outputs", {cpu_stall, cpu_nop, fl_erase_req}, 0);
    chk(periph_en, "R7 periph_en after reset", periph_en, 1);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R11 register reset", v, 0);
    end

    // R3 directed full erase
    wr(0, 8'h34); wr(1, 8'h12); wr(3, 8'h55); wr(3, 8'hAA);
    try_start(8'h07);

    // R6 busy extension and R9 writes ignored while busy
    fl_busy = 1;
    wr(0, 8'hAB); wr(1, 8'h00); wr(3, 8'h55); wr(3, 8'hAA);
    wr(2, 8'h07);
    @(negedge clk); @(negedge clk);
    reg_wr = 1; reg_addr = 0; reg_wdata = 8'h11;
    @(negedge clk);
    reg_wr = 0;
    repeat (EC + 10) @(negedge clk);
    chk(cpu_stall, "R6 busy keeps stall", cpu_stall, 1);
    fl_busy = 0;
    @(negedge clk);
    chk(!cpu_stall, "R6 stall ends after busy", cpu_stall, 0);
    rd(0, v);
    chk(v == 8'hAB, "R9 write during erase ignored", v, 8'hAB);

    // R2 write-enable clear, config select set
    wr(3, 8'h55); wr(3, 8'hAA); try_start(8'h05);
    wr(3, 8'h55); wr(3, 8'hAA); try_start(8'h0F);
    // R4 interposed address write, bad key, reversed key
    wr(3, 8'h55); wr(0, 8'h40); wr(3, 8'hAA); try_start(8'h07);
    wr(3, 8'h55); wr(3, 8'h12); wr(3, 8'hAA); try_start(8'h07);
    wr(3, 8'hAA); wr(3, 8'h55); try_start(8'h07);
    // R4 unlock consumed by a rejected start
    wr(3, 8'h55); wr(3, 8'hAA); wr(2, 8'h06); try_start(8'h07);

    // random key sequences (R3, R4)
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < 3; k++) begin
        int r;
        r = $urandom % 7;
        if (r < 2) wr(3, 8'h55);
        else if (r < 4) wr(3, 8'hAA);
        else if (r == 4) begin
          v = 8'($urandom);
          if (v == 8'h55 || v == 8'hAA) v = 8'h00;
          wr(3, v);
        end else wr(2'($urandom % 2), 8'($urandom));
      end
      v = {4'b0, ($urandom % 4) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0, 1'b1};
      try_start(v);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule